// File: doc/BRIEF.md
# Synthesizer Lock-Flag Monitor

This block decides whether a frequency synthesizer loop is locked by watching the up and down pulses that its phase detector sends to the charge pump. Both pump inputs are first brought into the crystal clock domain. The block then measures how long pump activity lasts in crystal-clock cycles. If activity lasts two or more cycles, the pulse is wider than one crystal period, and the lock flag drops at once. The flag comes back only after a fixed run of reference periods in which no such wide pulse appears.

The reference period comes from dividing the crystal clock by 64. With a 4 MHz crystal this gives a 62.5 kHz rate. The block emits a one-cycle strobe at the end of each reference period. A test select input can route the divided input signal and a square-wave form of the reference onto the two lowest general-purpose output ports. Otherwise every port passes through the value that software has set.

Top module: `pll_lock_monitor`

## Requirements
- R1: While reset is asserted and right after it, `lock_o` and `ref_tick_o` are 0 and `port_o` equals `port_sw_i`.
- R2: `ref_tick_o` is high for exactly one cycle in every 64. The first strobe comes in the 64th cycle after reset is released (sample 63, counting the cycle of release as 0).
- R3: Pump activity is the OR of `pump_up_i` and `pump_dn_i` after a two-flop synchronizer. If activity lasts two consecutive cycles, `lock_o` reads 0 after the third rising edge following the edge that first samples the pump input high.
- R4: A single isolated cycle of activity on either pump input leaves `lock_o` unchanged.
- R5: A cycle of `pump_up_i` followed directly by a cycle of `pump_dn_i` counts as one two-cycle activity run and clears the flag.
- R6: After a clear, `lock_o` rises on the edge that ends the ninth strobe cycle, counting from the cycle in which the wide run is detected and including that cycle. This holds even when detection falls in a strobe cycle.
- R7: After reset, with no pump activity, `lock_o` rises on the edge that ends the eighth strobe cycle.
- R8: Once set, `lock_o` stays 1 across any number of clean reference periods. The internal clean-period count saturates at 8.
- R9: When `test_sel_i` (bit 2 down to bit 0) is 3'b100, `port_o[0]` carries `fdiv_i`. In the same mode, `port_o[1]` is 1 for the 32 cycles that end with each strobe cycle and 0 for the other 32. `port_o[4:2]` always follows `port_sw_i[4:2]`, and every other select code passes `port_sw_i` through unchanged.
- R10: A wide run that arrives while the flag is being re-acquired restarts the count: the rise then follows the R6 rule, measured from the new detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pump_up_i | input | 1 | Charge-pump up pulse, asynchronous |
| pump_dn_i | input | 1 | Charge-pump down pulse, asynchronous |
| fdiv_i | input | 1 | Divided input signal for the test mux |
| test_sel_i | input | 3 | Test select bits; 3'b100 routes test signals |
| port_sw_i | input | 5 | Software values for the general-purpose ports |
| lock_o | output | 1 | Lock flag |
| ref_tick_o | output | 1 | One-cycle strobe at the end of each reference period |
| port_o | output | 5 | General-purpose output port values |

## Verification
The wide-pulse detection and the end-of-period strobe can fall in the same cycle. When they do, the detection must win: the closing period is counted as bad, and the next period still starts clean.

The bench triggers this overlap by sweeping the start of a two-cycle pump pulse across all 64 positions of a reference period, so that detection lands once on the strobe cycle and on each cycle around it. For each position, it counts strobes from the detection cycle (inferred from when the flag falls) and requires the flag to stay low through the ninth strobe cycle and be high on the next sample.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int DIV_RATIO   = 64,
  parameter int GOOD_RUN    = 8,
  parameter int WIDE_CYCLES = 2,
  parameter int SYNC_STAGES = 2,
  parameter int NPORT       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pump_up_i,
  input  logic             pump_dn_i,
  input  logic             fdiv_i,
  input  logic [2:0]       test_sel_i,
  input  logic [NPORT-1:0] port_sw_i,
  output logic             lock_o,
  output logic             ref_tick_o,
  output logic [NPORT-1:0] port_o
);

  localparam int DW = $clog2(DIV_RATIO);
  localparam int GW = $clog2(GOOD_RUN + 1);
  localparam int WW = $clog2(WIDE_CYCLES + 1);
  localparam logic [2:0] TEST_CODE = 3'b100;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_RATIO - 1);
  localparam logic [DW-1:0] DIV_HALF = DW'(DIV_RATIO / 2);
  localparam logic [WW-1:0] RUN_MAX  = WW'(WIDE_CYCLES - 1);
  localparam logic [GW-1:0] GOOD_TOP = GW'(GOOD_RUN);
  localparam logic [GW-1:0] GOOD_PRE = GW'(GOOD_RUN - 1);

  logic [SYNC_STAGES-1:0] up_sync, dn_sync;
  logic [WW-1:0]          run_len;
  logic [DW-1:0]          div_cnt;
  logic [GW-1:0]          good_cnt;
  logic                   bad_seen;
  logic                   pump_act, wide_hit, ref_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_sync <= '0;
      dn_sync <= '0;
    end else begin
      up_sync <= {up_sync[SYNC_STAGES-2:0], pump_up_i};
      dn_sync <= {dn_sync[SYNC_STAGES-2:0], pump_dn_i};
    end
  end

  assign pump_act = up_sync[SYNC_STAGES-1] | dn_sync[SYNC_STAGES-1];
  assign wide_hit = pump_act && (run_len >= RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_len <= '0;
    else if (!pump_act)
      run_len <= '0;
    else if (run_len < RUN_MAX)
      run_len <= run_len + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_cnt <= '0;
    else
      div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + 1'b1;
  end

  assign ref_tick_o = (div_cnt == DIV_LAST);
  assign ref_level  = (div_cnt >= DIV_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_seen <= 1'b0;
      good_cnt <= '0;
      lock_o   <= 1'b0;
    end else begin
      bad_seen <= ref_tick_o ? 1'b0 : (bad_seen | wide_hit);
      if (wide_hit) begin
        good_cnt <= '0;
        lock_o   <= 1'b0;
      end else if (ref_tick_o) begin
        if (bad_seen) begin
          good_cnt <= '0;
        end else begin
          if (good_cnt < GOOD_TOP) good_cnt <= good_cnt + 1'b1;
          if (good_cnt >= GOOD_PRE) lock_o <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    port_o = port_sw_i;
    if (test_sel_i == TEST_CODE) begin
      port_o[0] = fdiv_i;
      port_o[1] = ref_level;
    end
  end

endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk #(
  parameter int GOOD_RUN = 8,
  parameter int NPORT    = 5,
  parameter int GW       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_o,
  input logic             ref_tick_o,
  input logic             wide_hit,
  input logic [GW-1:0]    good_cnt,
  input logic [NPORT-1:0] port_o,
  input logic [NPORT-1:0] port_sw_i
);

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick_o |=> !ref_tick_o); // R2

  AST_WIDE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wide_hit |=> (!lock_o && good_cnt == '0)); // R3

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> ($past(ref_tick_o) && !$past(wide_hit))); // R6

  AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> ($past(good_cnt) == GW'(GOOD_RUN - 1))); // R7

  AST_GOOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    good_cnt <= GW'(GOOD_RUN)); // R8

  AST_UPPER_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    port_o[NPORT-1:2] == port_sw_i[NPORT-1:2]); // R9

endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(
  .GOOD_RUN(GOOD_RUN), .NPORT(NPORT), .GW(GW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_o(lock_o), .ref_tick_o(ref_tick_o),
  .wide_hit(wide_hit), .good_cnt(good_cnt), .port_o(port_o),
  .port_sw_i(port_sw_i)
);

// File: tb/pll_lock_monitor_test.sv
module pll_lock_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 64;
  localparam int RUN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pump_up = 1'b0, pump_dn = 1'b0, fdiv = 1'b0;
  logic [2:0] sel = 3'b000;
  logic [4:0] sw = 5'b10110;
  logic lock, tick;
  logic [4:0] port;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_monitor uut (
    .clk(clk), .rst_n(rst_n), .pump_up_i(pump_up), .pump_dn_i(pump_dn),
    .fdiv_i(fdiv), .test_sel_i(sel), .port_sw_i(sw),
    .lock_o(lock), .ref_tick_o(tick), .port_o(port)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  // Drives the pulse pattern from sample d; returns at sample d+3 (detection cycle).
  task automatic drive_wide(input int kind);
    case (kind)
      0: begin pump_up = 1'b1; @(negedge clk); @(negedge clk); pump_up = 1'b0; end
      1: begin pump_dn = 1'b1; @(negedge clk); @(negedge clk); pump_dn = 1'b0; end
      default: begin
        pump_up = 1'b1; @(negedge clk); pump_up = 1'b0; pump_dn = 1'b1;
        @(negedge clk); pump_dn = 1'b0;
      end
    endcase
    @(negedge clk);
  endtask

  // Called at the detection sample; checks fall, hold-off and rise.
  task automatic measure_relock(input string req, input bit prev_lock);
    int ticks;
    bit early;
    chk(req, "flag before clear", int'(lock), int'(prev_lock));
    ticks = int'(tick);
    @(negedge clk);
    chk("R3", "flag after wide run", int'(lock), 0);
    ticks += int'(tick);
    early = 1'b0;
    while (ticks < 9) begin
      @(negedge clk);
      early |= lock;
      ticks += int'(tick);
    end
    chk(req, "flag held low through ninth strobe", int'(early), 0);
    @(negedge clk);
    chk(req, "flag after ninth strobe", int'(lock), 1);
  endtask

  initial begin
    repeat (20000 * DIV / 8) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int ticks;
    bit seen;
    repeat (3) @(negedge clk);
    chk("R1", "lock in reset", int'(lock), 0);
    chk("R1", "tick in reset", int'(tick), 0);
    chk("R1", "ports in reset", int'(port), int'(sw));
    rst_n = 1'b1;
    n = 0;
    while (!tick) begin @(negedge clk); n++; end
    chk("R2", "first strobe sample", n, 63);
    n = 0;
    seen = 1'b0;
    do begin @(negedge clk); n++; if (n == 1) seen = tick; end while (!tick);
    chk("R2", "strobe width", int'(seen), 0);
    chk("R2", "strobe period", n, DIV);

    ticks = 2;
    seen = 1'b0;
    while (ticks < RUN) begin
      @(negedge clk);
      seen |= lock;
      ticks += int'(tick);
    end
    chk("R7", "flag before eighth strobe edge", int'(seen | lock), 0);
    @(negedge clk);
    chk("R7", "flag after eighth strobe", int'(lock), 1);

    // R4: isolated single cycles
    repeat (10) @(negedge clk);
    pump_up = 1'b1; @(negedge clk); pump_up = 1'b0;
    seen = 1'b0;
    repeat (8) begin @(negedge clk); seen |= !lock; end
    chk("R4", "single up cycle", int'(seen), 0);
    repeat (3) @(negedge clk);
    pump_dn = 1'b1; @(negedge clk); pump_dn = 1'b0;
    seen = 1'b0;
    repeat (8) begin @(negedge clk); seen |= !lock; end
    chk("R4", "single down cycle", int'(seen), 0);

    // R5: up then down, adjacent
    drive_wide(2);
    measure_relock("R5", 1'b1);

    // R3/R6: sweep detection position over every cycle of a period
    for (int off = 0; off < DIV; off++) begin
      wait_tick();
      repeat (off) @(negedge clk);
      drive_wide(off % 2);
      measure_relock("R6", 1'b1);
    end

    // R10: second wide run during re-acquisition
    wait_tick();
    repeat (20) @(negedge clk);
    drive_wide(0);
    @(negedge clk);
    chk("R3", "flag cleared before restart", int'(lock), 0);
    repeat (5) wait_tick();
    repeat (7) @(negedge clk);
    drive_wide(1);
    measure_relock("R10", 1'b0);

    // R8: flag holds over many clean periods
    seen = 1'b0;
    repeat (20) begin wait_tick(); seen |= !lock; end
    @(negedge clk);
    chk("R8", "flag held over clean periods", int'(seen | !lock), 0);

    // R9: pass-through for every non-test code
    fdiv = 1'b1;
    for (int c = 0; c < 8; c++) begin
      if (c != 4) begin
        sel = 3'(c);
        @(negedge clk);
        chk("R9", "pass-through port", int'(port), int'(sw));
      end
    end
    sel = 3'b100;
    wait_tick();
    seen = 1'b0;
    for (int k = 1; k <= DIV; k++) begin
      fdiv = 1'(k % 3 == 0);
      @(negedge clk);
      seen |= (port[1] != (k >= 33));
      seen |= (port[0] != fdiv);
      seen |= (port[4:2] != sw[4:2]);
    end
    chk("R9", "test mux over one period", int'(seen), 0);
    chk("R9", "strobe at end of sweep", int'(tick), 1);
    sel = 3'b000;

    // R1: mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "lock after mid-run reset", int'(lock), 0);
    chk("R1", "tick after mid-run reset", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule